// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Four-Word Lines

This block is a data cache placed between a requester that issues 32-bit byte-addressed word reads and writes and a slower lower-level memory. Every address maps to exactly one line. Each line holds a valid flag, a stored tag and a block of four 32-bit words. When the indexed line is valid and its tag matches, a read returns the addressed word combinationally in the same cycle.

On a read miss the requester is stalled. The block-aligned address is sent to the lower memory over a request/grant handshake, and four words come back one per beat. The line is written in one step, and the held request then hits and completes.

Writes use a write-through policy. A write that misses first pulls in the whole block. A write that hits updates the addressed word and posts the word-aligned address and data to a write-buffer port in the same cycle. If the write buffer signals that it is full, the write is held off until space frees.

Top module: `wt_dm_cache`

## Requirements
- R1: The byte address is split as tag = bits 31:16, line index = bits 15:4, word-in-line = bits 3:2. Bits 1:0 have no effect on which word is read or written.
- R2: After reset no line is valid, so the first access to any index misses and triggers one block fetch. While idle after reset, cpu_stall, mem_req and wb_valid are 0.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit completes with cpu_stall low in its first cycle, with no fetch.
- R4: The word-in-line field picks word k of the line. Word k is the data that arrived on refill beat k or was last written at that word address.
- R5: On a read miss cpu_stall stays high. mem_req rises with mem_addr equal to the address with bits 3:0 cleared, and mem_req and mem_addr hold steady until mem_gnt. Then exactly four mem_rvalid beats are taken, for words 0 to 3 in order.
- R6: The line's tag, all four words and its valid flag are written at the clock edge that takes the fourth beat. The held access hits in the following cycle.
- R7: A write miss fetches the whole block first and then writes the addressed word. The other three words keep their fetched values.
- R8: A write hit updates the word in the line and, in the same cycle, drives wb_valid high with wb_addr equal to the address with bits 1:0 cleared and wb_data equal to cpu_wdata.
- R9: While wb_full is high, a write keeps cpu_stall high and wb_valid low, and it completes once wb_full falls. Reads are not held off by wb_full.
- R10: An access whose tag differs from the valid tag at its index misses and replaces that line. A later access with the old tag misses again and gets the written-through value back from lower memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when a read is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Block fetch request to lower memory |
| mem_addr | output | 32 | Block-aligned fetch address |
| mem_gnt | input | 1 | Lower memory accepts the fetch request |
| mem_rvalid | input | 1 | One refill word is present |
| mem_rdata | input | 32 | Refill word, words 0 to 3 in order |
| wb_valid | output | 1 | Write posted to the write buffer |
| wb_addr | output | 32 | Word-aligned write address |
| wb_data | output | 32 | Write word |
| wb_full | input | 1 | Write buffer cannot take an entry |

## Verification
Two events share a cycle boundary here. The last refill beat and the write that waited for it fall on consecutive edges, so the write must merge into the freshly filled line without being lost or overwriting the neighbouring words. Write-buffer back-pressure can also meet a write that already hits. The bench provokes the first with a write to an unseen block and then reads back all four words of that line. It provokes the second by raising wb_full under a hitting write, holding it for several cycles, and judging that the stall, a silent wb_valid and a single post happen only after wb_full falls.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
    typedef enum logic [1:0] {
        RF_IDLE = 2'd0,
        RF_REQ  = 2'd1,
        RF_BEAT = 2'd2
    } refill_state_e;
endpackage

// File: rtl/wt_cache_tags.sv
module wt_cache_tags #(
    parameter int unsigned INDEX_W = 12,
    parameter int unsigned TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               hit,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag
);
    localparam int unsigned LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        valid_d = valid_q;
        if (fill_en) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end

    assign hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    AST_FILL_MAKES_LINE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag))); // R6
endmodule

// File: rtl/wt_cache_data.sv
module wt_cache_data #(
    parameter int unsigned INDEX_W = 12,
    parameter int unsigned WORDS   = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INDEX_W-1:0]      rd_idx,
    input  logic [$clog2(WORDS)-1:0] rd_woff,
    output logic [DATA_W-1:0]       rd_word,
    input  logic                    fill_en,
    input  logic [INDEX_W-1:0]      fill_idx,
    input  logic [WORDS*DATA_W-1:0] fill_line,
    input  logic                    wr_en,
    input  logic [INDEX_W-1:0]      wr_idx,
    input  logic [$clog2(WORDS)-1:0] wr_woff,
    input  logic [DATA_W-1:0]       wr_word
);
    localparam int unsigned LINES  = 1 << INDEX_W;
    localparam int unsigned LINE_W = WORDS * DATA_W;
    localparam int unsigned WOFF_W = $clog2(WORDS);

    logic [LINE_W-1:0] line_q [LINES];
    logic [DATA_W-1:0] lane [WORDS];

    always_ff @(posedge clk) begin
        if (fill_en)
            line_q[fill_idx] <= fill_line;
        else if (wr_en)
            line_q[wr_idx][wr_woff*DATA_W +: DATA_W] <= wr_word;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        assign lane[g] = line_q[rd_idx][g*DATA_W +: DATA_W];
    end

    assign rd_word = lane[rd_woff];

    // shadow of the last word write, used only by the checks below
    logic               chk_en_q;
    logic [INDEX_W-1:0] chk_idx_q;
    logic [WOFF_W-1:0]  chk_woff_q;
    logic [DATA_W-1:0]  chk_word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chk_en_q <= 1'b0;
        else        chk_en_q <= wr_en;
        chk_idx_q  <= wr_idx;
        chk_woff_q <= wr_woff;
        chk_word_q <= wr_word;
    end

    AST_FILL_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && wr_en)); // R7
    AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_q |-> (line_q[chk_idx_q][chk_woff_q*DATA_W +: DATA_W] == chk_word_q)); // R8
endmodule

// File: rtl/wt_cache_refill.sv
module wt_cache_refill
    import wt_cache_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WORDS     = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BLK_OFF_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ADDR_W-BLK_OFF_W-1:0] start_blk,
    output logic                        busy,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_gnt,
    input  logic                        mem_rvalid,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        fill_en,
    output logic [ADDR_W-BLK_OFF_W-1:0] fill_blk,
    output logic [WORDS*DATA_W-1:0]     fill_line
);
    localparam int unsigned CNT_W  = $clog2(WORDS);
    localparam int unsigned LINE_W = WORDS * DATA_W;
    localparam int unsigned BLK_W  = ADDR_W - BLK_OFF_W;

    typedef struct packed {
        refill_state_e     st;
        logic [BLK_W-1:0]  blk;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] blkbuf;
    } refill_t;

    refill_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        fill_en = 1'b0;
        unique case (r_q.st)
            RF_IDLE: begin
                if (start) begin
                    r_d.st  = RF_REQ;
                    r_d.blk = start_blk;
                    r_d.cnt = '0;
                end
            end
            RF_REQ: begin
                if (mem_gnt) r_d.st = RF_BEAT;
            end
            RF_BEAT: begin
                if (mem_rvalid) begin
                    r_d.blkbuf[r_q.cnt*DATA_W +: DATA_W] = mem_rdata;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(WORDS-1)) begin
                        fill_en = 1'b1;
                        r_d.st  = RF_IDLE;
                    end
                end
            end
            default: r_d.st = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= RF_IDLE;
            r_q.blk    <= '0;
            r_q.cnt    <= '0;
            r_q.blkbuf <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != RF_IDLE);
    assign mem_req   = (r_q.st == RF_REQ);
    assign mem_addr  = {r_q.blk, {BLK_OFF_W{1'b0}}};
    assign fill_blk  = r_q.blk;
    assign fill_line = r_d.blkbuf;

    AST_REQ_HELD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R5
    AST_REQ_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[BLK_OFF_W-1:0] == '0)); // R5
    AST_FILL_ONLY_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> !busy); // R6
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned INDEX_W = 12,
    parameter int unsigned WORDS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_full
);
    localparam int unsigned BYTE_OFF_W = $clog2(DATA_W / 8);
    localparam int unsigned WOFF_W     = $clog2(WORDS);
    localparam int unsigned BLK_OFF_W  = WOFF_W + BYTE_OFF_W;
    localparam int unsigned TAG_W      = ADDR_W - INDEX_W - BLK_OFF_W;
    localparam int unsigned BLK_W      = ADDR_W - BLK_OFF_W;
    localparam int unsigned LINE_W     = WORDS * DATA_W;

    logic [TAG_W-1:0]      a_tag;
    logic [INDEX_W-1:0]    a_idx;
    logic [WOFF_W-1:0]     a_woff;
    logic [BYTE_OFF_W-1:0] byte_unused;
    logic                  hit, busy, start, accept, wr_en;
    logic                  fill_en;
    logic [BLK_W-1:0]      fill_blk;
    logic [LINE_W-1:0]     fill_line;

    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx       = cpu_addr[BLK_OFF_W +: INDEX_W];
    assign a_woff      = cpu_addr[BYTE_OFF_W +: WOFF_W];
    assign byte_unused = cpu_addr[BYTE_OFF_W-1:0];

    assign start     = cpu_req && !hit && !busy;
    assign accept    = cpu_req && hit && !busy && (!cpu_we || !wb_full);
    assign wr_en     = accept && cpu_we;
    assign cpu_stall = cpu_req && !accept;

    assign wb_valid = wr_en;
    assign wb_addr  = {cpu_addr[ADDR_W-1:BYTE_OFF_W], {BYTE_OFF_W{1'b0}}};
    assign wb_data  = cpu_wdata;

    wt_cache_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (a_idx),
        .lk_tag   (a_tag),
        .hit      (hit),
        .fill_en  (fill_en),
        .fill_idx (fill_blk[INDEX_W-1:0]),
        .fill_tag (fill_blk[BLK_W-1 -: TAG_W])
    );

    wt_cache_data #(.INDEX_W(INDEX_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (a_idx),
        .rd_woff   (a_woff),
        .rd_word   (cpu_rdata),
        .fill_en   (fill_en),
        .fill_idx  (fill_blk[INDEX_W-1:0]),
        .fill_line (fill_line),
        .wr_en     (wr_en),
        .wr_idx    (a_idx),
        .wr_woff   (a_woff),
        .wr_word   (cpu_wdata)
    );

    wt_cache_refill #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_OFF_W(BLK_OFF_W)) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_blk  (cpu_addr[ADDR_W-1:BLK_OFF_W]),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fill_en    (fill_en),
        .fill_blk   (fill_blk),
        .fill_line  (fill_line)
    );

    AST_POST_NEVER_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !wb_full); // R9
    AST_POST_ONLY_COMPLETED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (cpu_we && !cpu_stall)); // R8
    AST_STALL_DURING_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_req) |-> cpu_stall); // R5
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !cpu_stall); // R2
endmodule

// File: tb/wt_dm_cache_tb.sv
module wt_dm_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        wb_valid, wb_full;
    logic [31:0] wb_addr, wb_data;

    always #5 clk = ~clk;

    wt_dm_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_full(wb_full)
    );

    int          errors = 0;
    int          checks = 0;
    int          fetches = 0;
    bit          done = 0;
    logic [31:0] last_fetch = '0;
    logic [31:0] lowmem [logic [31:0]];

    function automatic logic [31:0] memf(input logic [31:0] a);
        if (lowmem.exists(a)) return lowmem[a];
        return (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // lower memory: grant one cycle, then four beats, words 0..3
    initial begin
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 0; mem_rvalid = 0;
            if (rst_n === 1'b1 && mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                last_fetch = a;
                fetches++;
                mem_gnt = 1;
                @(negedge clk);
                mem_gnt = 0;
                for (int k = 0; k < 4; k++) begin
                    mem_rvalid = 1;
                    mem_rdata  = memf(a + 32'(4 * k));
                    @(negedge clk);
                end
                mem_rvalid = 0;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] data,
                          output logic [31:0] rd, output int stalls,
                          output logic wbv, output logic [31:0] wba, output logic [31:0] wbd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = data;
        stalls = 0;
        #2;
        while (cpu_stall && stalls < 300) begin
            @(negedge clk); #2;
            stalls++;
        end
        rd = cpu_rdata; wbv = wb_valid; wba = wb_addr; wbd = wb_data;
        if (wbv) lowmem[wba] = wbd;
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
    endtask

    // {we, miss, addr, data}
    localparam int NV = 15;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 1'b1, 32'h0000_1230, 32'h0},          // R2 first access misses
        {1'b0, 1'b0, 32'h0000_1234, 32'h0},          // R3 R4 word 1
        {1'b0, 1'b0, 32'h0000_123C, 32'h0},          // R4 word 3
        {1'b1, 1'b0, 32'h0000_1238, 32'hDEAD_BEEF},  // R8 write hit
        {1'b0, 1'b0, 32'h0000_1238, 32'h0},          // R8 readback
        {1'b0, 1'b1, 32'h0005_1230, 32'h0},          // R10 conflict
        {1'b0, 1'b1, 32'h0000_1238, 32'h0},          // R10 old tag misses
        {1'b1, 1'b1, 32'h0007_0044, 32'h1234_5678},  // R7 write miss
        {1'b0, 1'b0, 32'h0007_0040, 32'h0},          // R7 word 0 fetched
        {1'b0, 1'b0, 32'h0007_0044, 32'h0},          // R7 written word
        {1'b0, 1'b0, 32'h0007_0047, 32'h0},          // R1 byte offset ignored
        {1'b0, 1'b0, 32'h0007_004C, 32'h0},          // R7 word 3 fetched
        {1'b0, 1'b1, 32'hFFFF_FFF0, 32'h0},          // R1 top index
        {1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0},          // R4
        {1'b0, 1'b1, 32'h0000_0000, 32'h0}           // R2 index 0 never filled
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, wba, wbd, exp;
        logic        wbv;
        int          st, f0;
        rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; wb_full = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        chk(cpu_stall == 0, "R2 reset stall", 32'(cpu_stall), 0);
        chk(mem_req == 0, "R2 reset mem_req", 32'(mem_req), 0);
        chk(wb_valid == 0, "R2 reset wb_valid", 32'(wb_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic        we, miss;
            logic [31:0] a, d;
            {we, miss, a, d} = VEC[i];
            f0 = fetches;
            access(we, a, d, rd, st, wbv, wba, wbd);
            chk((fetches - f0) == int'(miss), $sformatf("R3 R5 R10 vec%0d fetch count", i),
                32'(fetches - f0), 32'(miss));
            if (miss) begin
                chk(last_fetch == {a[31:4], 4'h0}, $sformatf("R5 vec%0d fetch addr", i),
                    last_fetch, {a[31:4], 4'h0});
                chk(st > 0, $sformatf("R5 vec%0d stalled", i), 32'(st), 1);
            end else begin
                chk(st == 0, $sformatf("R3 vec%0d hit no stall", i), 32'(st), 0);
            end
            if (we) begin
                chk(wbv == 1 && wba == {a[31:2], 2'b00} && wbd == d,
                    $sformatf("R8 vec%0d post", i), wba, {a[31:2], 2'b00});
            end else begin
                exp = memf({a[31:2], 2'b00});
                chk(rd == exp, $sformatf("R4 R6 vec%0d read data", i), rd, exp);
                chk(wbv == 0, $sformatf("R8 vec%0d no post on read", i), 32'(wbv), 0);
            end
        end

        // R9: write hit held off by a full write buffer
        @(negedge clk);
        wb_full = 1; cpu_req = 1; cpu_we = 1; cpu_addr = 32'h0000_1230; cpu_wdata = 32'hCAFE_F00D;
        for (int c = 0; c < 3; c++) begin
            #2;
            chk(cpu_stall == 1, "R9 full stalls write", 32'(cpu_stall), 1);
            chk(wb_valid == 0, "R9 full no post", 32'(wb_valid), 0);
            @(negedge clk);
        end
        wb_full = 0;
        #2;
        chk(cpu_stall == 0 && wb_valid == 1, "R9 write completes after full drops",
            {cpu_stall, wb_valid}, 32'h1);
        chk(wb_data == 32'hCAFE_F00D, "R9 posted data", wb_data, 32'hCAFE_F00D);
        if (wb_valid) lowmem[wb_addr] = wb_data;
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;

        // R9: reads are not held off by wb_full
        wb_full = 1;
        f0 = fetches;
        access(1'b0, 32'h0000_1230, 32'h0, rd, st, wbv, wba, wbd);
        chk(st == 0, "R9 read not stalled by full", 32'(st), 0);
        chk(rd == 32'hCAFE_F00D, "R9 R8 read of written word", rd, 32'hCAFE_F00D);
        chk(fetches == f0, "R9 read hit no fetch", 32'(fetches - f0), 0);
        wb_full = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule